// File: doc/BRIEF.md
# Authenticated-Encryption Output Sequencer

This block turns a packet of 128-bit words into the output stream of counter-mode authenticated encryption. Each packet arrives as one word per cycle with no gaps: one or more header words (the last of which carries the 96-bit nonce in its top bits), then one or more payload words. The block issues counter blocks to an external block-cipher pipeline and combines the returned keystream with the payload to form ciphertext. It feeds every header and ciphertext word, and then a lengths word, to an external universal-hash unit. After the last ciphertext word it emits the truncated authentication tag.

A fixed-length delay FIFO hides the cipher pipeline's latency. Every input word leaves the block a fixed number of cycles after it enters, and the tag follows the last ciphertext word with no idle cycle between them. The cipher pipeline must answer each counter block exactly 10 cycles after it is issued. The hash unit must absorb one word per cycle, and its running value must be visible the cycle after each word it absorbs. Packets must be separated by at least 16 idle input cycles.

Top module: `gcm_seq`

## Requirements
- R1: After reset, out_valid, ctr_valid and gh_valid are low, and out_valid stays low until a packet's first word has passed through the block.
- R2: A header word (in_payload low) appears on out_data unchanged, with out_type 2'b01.
- R3: Payload word j of a packet (j counting from 0) appears as that word XOR the keystream returned for counter block j+1, with out_type 2'b10.
- R4: The cycle after the first payload word is accepted, ctr_block is the top 96 bits of the packet's last header word followed by 32'd1. Each later cycle issues the previous block with its low 32 bits incremented modulo 2^32. A packet with n payload words issues n+1 blocks on consecutive cycles.
- R5: The first keystream word of a packet (from the initial counter block) is never applied to payload. It is held and used only to form the tag.
- R6: Input word k of a packet appears on the outputs 14 cycles after the cycle it is accepted, and the words of a packet leave on consecutive cycles.
- R7: On the last payload word, in_bits = u (1..128) keeps only the top u bits of the ciphertext and forces the rest to zero, both on out_data and on gh_data. A value of 0 or above 128 means a full word.
- R8: Each header or ciphertext word is driven on gh_data with gh_valid high 12 cycles after it is accepted, and gh_first marks the first word of a packet. The next cycle after the last one carries the lengths word: header bit count in bits 127:64, ciphertext bit count in bits 63:0.
- R9: The cycle after the last ciphertext word is output, the block outputs out_type 2'b11 with out_data equal to the top TAG_BITS bits of (gh_hash XOR the held keystream word), with the lower bits zero. gh_hash is sampled the cycle after the lengths word.
- R10: The FIFO accepts 12 words before it releases the first one. In a packet longer than 12 words, it writes and reads in the same cycle without losing or reordering a word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input word present |
| in_payload | input | 1 | 1 = payload word, 0 = header/sequence word |
| in_last | input | 1 | Last word of the packet (must be a payload word) |
| in_bits | input | 8 | Valid bits of the last payload word |
| in_data | input | 128 | Input word |
| ctr_valid | output | 1 | Counter block issued to the cipher pipeline |
| ctr_block | output | 128 | Counter block |
| ks_valid | input | 1 | Keystream word present |
| ks_data | input | 128 | Keystream word |
| gh_valid | output | 1 | Word offered to the hash unit |
| gh_first | output | 1 | First hash word of a packet (hash restarts) |
| gh_data | output | 128 | Word for the hash unit |
| gh_hash | input | 128 | Current hash value from the hash unit |
| out_valid | output | 1 | Output word present |
| out_type | output | 2 | 01 header, 10 ciphertext, 11 tag |
| out_data | output | 128 | Output word |

## Verification
Two pairs of functions can coincide in one cycle. First, in a packet longer than 12 words the FIFO writes a new word and releases an old one on the same edge, while it is full. Second, the last ciphertext word leaves the delay register while the lengths word goes to the hash unit, and the tag is built from the hash result one cycle later. Packets of up to 22 words provoke the first case. Every packet provokes the second. Both are judged by comparing each output cycle, the lengths word and the tag against a bench model of the cipher and hash units. Truncated last blocks of 1 and 64 bits, and an out-of-range bit count, are included.

// File: rtl/gcm_seq_pkg.sv
// Shared types and helpers for the output sequencer.
// Assumes a 128-bit block size fixed by the cipher.
package gcm_seq_pkg;
    localparam int BLK = 128;

    typedef enum logic [1:0] {
        OT_NONE = 2'b00,
        OT_HDR  = 2'b01,
        OT_CIPH = 2'b10,
        OT_TAG  = 2'b11
    } otype_e;

    // One FIFO slot: word, kind, end flag and valid bit count.
    typedef struct packed {
        logic [BLK-1:0] data;
        logic           pay;
        logic           last;
        logic [7:0]     bits;
    } slot_t;

    // Mask keeping the n most significant bits of a block.
    function automatic logic [BLK-1:0] msb_keep(input logic [7:0] n);
        return ~({BLK{1'b1}} >> n);
    endfunction

    // Increment of the low 32 bits, upper part unchanged.
    function automatic logic [BLK-1:0] inc32(input logic [BLK-1:0] y);
        return {y[BLK-1:32], y[31:0] + 32'd1};
    endfunction
endpackage

// File: rtl/gcm_seq_fifo.sv
// Fill-then-stream delay FIFO.
// When a packet begins on an idle FIFO, reads stay off for DEPTH cycles, then
// run every cycle until the slot marked last has been read.
// Assumes contiguous input within a packet and an idle gap between packets.
module gcm_seq_fifo
    import gcm_seq_pkg::*;
#(
    parameter int DEPTH = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr,
    input  slot_t                    wslot,
    output logic                     rd,
    output slot_t                    rslot,
    output logic                     filling,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    slot_t          mem [DEPTH];
    logic [PW-1:0]  wptr, rptr;
    logic [CW-1:0]  fcnt;
    logic           running;

    assign rd    = running && (count != '0);
    assign rslot = mem[rptr];

    // Slot storage: write at the write pointer.
    always_ff @(posedge clk) begin
        if (wr) mem[wptr] <= wslot;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (wr) wptr <= (wptr == PW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            if (rd) rptr <= (rptr == PW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            count <= count + CW'(wr) - CW'(rd);
        end
    end

    // Fill phase timing and streaming phase control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filling <= 1'b0;
            running <= 1'b0;
            fcnt    <= '0;
        end else if (!filling && !running && wr) begin
            filling <= 1'b1;
            fcnt    <= CW'(1);
        end else if (filling) begin
            fcnt <= fcnt + 1'b1;
            if (fcnt == CW'(DEPTH - 1)) begin
                filling <= 1'b0;
                running <= 1'b1;
            end
        end else if (rd && rslot.last) begin
            running <= 1'b0;
        end
    end
endmodule

// File: rtl/gcm_seq_ctr.sv
// Counter block issuer.
// Holds the nonce from the most recent header word. On the first payload word
// it issues nonce||1, then increments once per payload word plus one extra.
// Assumes at least one header word precedes the payload.
module gcm_seq_ctr
    import gcm_seq_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr,
    input  slot_t          wslot,
    output logic           y0_load,
    output logic           ctr_valid,
    output logic [BLK-1:0] ctr_block
);
    logic [BLK-33:0] nonce_q;
    logic            prev_pay;
    logic            tail;
    logic            issue;

    assign y0_load = wr && wslot.pay && !prev_pay;
    assign issue   = (wr && wslot.pay) || tail;

    // Track nonce and the header/payload boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nonce_q  <= '0;
            prev_pay <= 1'b0;
            tail     <= 1'b0;
        end else begin
            if (wr && !wslot.pay) nonce_q <= wslot.data[BLK-1:32];
            if (wr) prev_pay <= wslot.pay;
            tail <= wr && wslot.pay && wslot.last;
        end
    end

    // Issue counter blocks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctr_valid <= 1'b0;
            ctr_block <= '0;
        end else begin
            ctr_valid <= issue;
            if (y0_load)    ctr_block <= {nonce_q, 32'd1};
            else if (issue) ctr_block <= inc32(ctr_block);
        end
    end
endmodule

// File: rtl/gcm_seq_emit.sv
// Output stage: XOR with keystream, hash feed, length counts, tag build.
// The delay register lines ciphertext up so the tag, formed one cycle after
// the lengths word, follows the last ciphertext word directly.
// Assumes keystream for a payload slot is valid in the cycle the slot is read.
module gcm_seq_emit
    import gcm_seq_pkg::*;
#(
    parameter int TAG_BITS = 96
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           rd,
    input  slot_t          head,
    input  logic           y0_load,
    input  logic           ks_valid,
    input  logic [BLK-1:0] ks_data,
    input  logic [BLK-1:0] gh_hash,
    output logic           gh_valid,
    output logic           gh_first,
    output logic [BLK-1:0] gh_data,
    output logic           out_valid,
    output logic [1:0]     out_type,
    output logic [BLK-1:0] out_data
);
    logic [BLK-1:0] ek0;
    logic           ek0_wait;
    logic           first_pend;
    logic [63:0]    alen, clen;
    logic           len_now, tag_now;
    logic           s1_valid;
    otype_e         s1_type;
    logic [BLK-1:0] s1_data;
    logic [BLK-1:0] word;
    logic [BLK-1:0] tag_word;

    // Word as it leaves the FIFO, encrypted and trimmed when payload.
    always_comb begin
        word = head.data;
        if (head.pay) word = (head.data ^ ks_data) & msb_keep(head.bits);
    end

    assign gh_valid = rd || len_now;
    assign gh_first = rd && first_pend;
    assign gh_data  = len_now ? {alen, clen} : word;
    assign tag_word = (gh_hash ^ ek0) & msb_keep(8'(TAG_BITS));

    // Hold the first keystream word of each packet for the tag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ek0      <= '0;
            ek0_wait <= 1'b0;
        end else if (y0_load) begin
            ek0_wait <= 1'b1;
        end else if (ks_valid && ek0_wait) begin
            ek0      <= ks_data;
            ek0_wait <= 1'b0;
        end
    end

    // Packet phase flags and bit-length accumulation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_now    <= 1'b0;
            tag_now    <= 1'b0;
            first_pend <= 1'b1;
            alen       <= '0;
            clen       <= '0;
        end else begin
            len_now <= rd && head.last;
            tag_now <= len_now;
            if (rd)           first_pend <= 1'b0;
            else if (len_now) first_pend <= 1'b1;
            if (len_now) begin
                alen <= '0;
                clen <= '0;
            end else if (rd) begin
                if (head.pay) clen <= clen + {56'd0, head.bits};
                else          alen <= alen + 64'd128;
            end
        end
    end

    // One-cycle delay register for header and ciphertext words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_type  <= OT_NONE;
            s1_data  <= '0;
        end else begin
            s1_valid <= rd;
            s1_type  <= rd ? (head.pay ? OT_CIPH : OT_HDR) : OT_NONE;
            s1_data  <= rd ? word : '0;
        end
    end

    // Output register: tag or delayed word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_type  <= OT_NONE;
            out_data  <= '0;
        end else if (tag_now) begin
            out_valid <= 1'b1;
            out_type  <= OT_TAG;
            out_data  <= tag_word;
        end else begin
            out_valid <= s1_valid;
            out_type  <= s1_type;
            out_data  <= s1_data;
        end
    end
endmodule

// File: rtl/gcm_seq.sv
// Top of the authenticated-encryption output sequencer.
// Buffers the packet in a delay FIFO, issues counter blocks, encrypts payload
// with the returned keystream, feeds the hash unit and appends the tag.
// Assumes a 10-cycle cipher pipeline and at least 16 idle cycles between packets.
module gcm_seq
    import gcm_seq_pkg::*;
#(
    parameter int DEPTH    = 12,
    parameter int TAG_BITS = 96
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic         in_payload,
    input  logic         in_last,
    input  logic [7:0]   in_bits,
    input  logic [127:0] in_data,
    output logic         ctr_valid,
    output logic [127:0] ctr_block,
    input  logic         ks_valid,
    input  logic [127:0] ks_data,
    output logic         gh_valid,
    output logic         gh_first,
    output logic [127:0] gh_data,
    input  logic [127:0] gh_hash,
    output logic         out_valid,
    output logic [1:0]   out_type,
    output logic [127:0] out_data
);
    localparam int CW = $clog2(DEPTH + 1);

    slot_t         wslot, head;
    logic          fifo_rd, fifo_filling, y0_load;
    logic [CW-1:0] fifo_count;
    logic          bits_ok;

    // Slot formation; a bit count outside 1..128 means a full block.
    assign bits_ok = (in_bits != 8'd0) && (in_bits <= 8'd128);
    always_comb begin
        wslot.data = in_data;
        wslot.pay  = in_payload;
        wslot.last = in_last;
        wslot.bits = (in_payload && in_last && bits_ok) ? in_bits : 8'd128;
    end

    gcm_seq_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .wr(in_valid), .wslot(wslot),
        .rd(fifo_rd), .rslot(head), .filling(fifo_filling), .count(fifo_count)
    );

    gcm_seq_ctr u_ctr (
        .clk(clk), .rst_n(rst_n), .wr(in_valid), .wslot(wslot),
        .y0_load(y0_load), .ctr_valid(ctr_valid), .ctr_block(ctr_block)
    );

    gcm_seq_emit #(.TAG_BITS(TAG_BITS)) u_emit (
        .clk(clk), .rst_n(rst_n), .rd(fifo_rd), .head(head), .y0_load(y0_load),
        .ks_valid(ks_valid), .ks_data(ks_data), .gh_hash(gh_hash),
        .gh_valid(gh_valid), .gh_first(gh_first), .gh_data(gh_data),
        .out_valid(out_valid), .out_type(out_type), .out_data(out_data)
    );
endmodule

// File: rtl/gcm_seq_chk.sv
// Property checker for the output sequencer, bound to the top module.
module gcm_seq_chk #(
    parameter int DEPTH = 12
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       ks_valid,
    input logic                       ctr_valid,
    input logic [127:0]               ctr_block,
    input logic                       gh_data_low_zero,
    input logic                       out_valid,
    input logic [1:0]                 out_type,
    input logic                       rd,
    input logic                       head_pay,
    input logic [7:0]                 head_bits,
    input logic                       len_now,
    input logic                       filling,
    input logic [$clog2(DEPTH+1)-1:0] fcount
);
    // R3
    ks_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && head_pay) |-> ks_valid);

    // R7
    part_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && head_pay && head_bits == 8'd1) |-> gh_data_low_zero);

    // R9
    tag_after_ciph_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_type == 2'b11) |-> ($past(out_valid) && $past(out_type) == 2'b10));

    // R8
    len_then_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        len_now |=> ##1 (out_valid && out_type == 2'b11));

    // R10
    fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fcount <= ($clog2(DEPTH+1))'(DEPTH));

    // R6
    fill_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        filling |-> !out_valid);

    // R4
    y0_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctr_valid) |-> ctr_block[31:0] == 32'd1);
endmodule

bind gcm_seq gcm_seq_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .ks_valid(ks_valid),
    .ctr_valid(ctr_valid), .ctr_block(ctr_block),
    .gh_data_low_zero(gh_data[126:0] == 127'd0),
    .out_valid(out_valid), .out_type(out_type),
    .rd(fifo_rd), .head_pay(head.pay), .head_bits(head.bits),
    .len_now(u_emit.len_now), .filling(fifo_filling), .fcount(fifo_count)
);

// File: tb/gcm_seq_test.sv
`timescale 1ns/1ps
module gcm_seq_test;
    localparam int TB = 96;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0, in_payload = 1'b0, in_last = 1'b0;
    logic [7:0]   in_bits = 8'd0;
    logic [127:0] in_data = '0;
    logic         ctr_valid, gh_valid, gh_first, out_valid;
    logic [127:0] ctr_block, gh_data, out_data;
    logic [1:0]   out_type;
    logic         ks_valid;
    logic [127:0] ks_data, ghx;
    logic [128:0] kpipe [10];

    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    gcm_seq #(.DEPTH(12), .TAG_BITS(TB)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_payload(in_payload),
        .in_last(in_last), .in_bits(in_bits), .in_data(in_data),
        .ctr_valid(ctr_valid), .ctr_block(ctr_block),
        .ks_valid(ks_valid), .ks_data(ks_data),
        .gh_valid(gh_valid), .gh_first(gh_first), .gh_data(gh_data), .gh_hash(ghx),
        .out_valid(out_valid), .out_type(out_type), .out_data(out_data)
    );

    // Stand-in cipher: any fixed mapping of the counter block.
    function automatic logic [127:0] kf(input logic [127:0] b);
        return {b[95:0], b[127:96]} ^ 128'h3c5a_9e01_77d2_4b18_c0fe_1234_89ab_6d5f;
    endfunction

    // Stand-in hash step.
    function automatic logic [127:0] mixf(input logic [127:0] x, input logic [127:0] d);
        return {x[126:0], x[127]} ^ d;
    endfunction

    function automatic logic [127:0] topmask(input int n);
        logic [127:0] m = '0;
        for (int i = 0; i < n; i++) m[127-i] = 1'b1;
        return m;
    endfunction

    // Environment: 10-cycle keystream pipeline.
    assign ks_valid = kpipe[9][128];
    assign ks_data  = kpipe[9][127:0];
    always @(posedge clk) begin
        kpipe[0] <= {ctr_valid, kf(ctr_block)};
        for (int i = 1; i < 10; i++) kpipe[i] <= kpipe[i-1];
    end

    // Environment: hash unit updating one cycle after each word.
    always @(posedge clk) begin
        if (!rst_n)        ghx <= '0;
        else if (gh_valid) ghx <= mixf(gh_first ? 128'd0 : ghx, gh_data);
    end

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    logic [127:0] wd [40];
    logic [127:0] ex [40];
    logic [127:0] yv [40];

    task automatic run_packet(input int h, input int np, input int rawbits);
        int L = h + np;
        int u = (rawbits == 0 || rawbits > 128) ? 128 : rawbits;
        logic [127:0] x = '0;
        logic [127:0] tag;
        logic [127:0] lens;
        logic [63:0] clen;
        for (int k = 0; k < L; k++) wd[k] = {$urandom, $urandom, $urandom, $urandom};
        yv[0] = {wd[h-1][127:32], 32'd1};
        for (int j = 1; j <= np; j++) yv[j] = {yv[j-1][127:32], yv[j-1][31:0] + 32'd1};
        for (int k = 0; k < L; k++) begin
            if (k < h) ex[k] = wd[k];
            else ex[k] = (wd[k] ^ kf(yv[k-h+1])) & topmask((k == L-1) ? u : 128);
            x = mixf((k == 0) ? 128'd0 : x, ex[k]);
        end
        clen = 64'(128 * (np - 1) + u);
        lens = {64'(128 * h), clen};
        x = mixf(x, lens);
        tag = (x ^ kf(yv[0])) & topmask(TB);

        @(negedge clk);
        in_valid = 1'b1; in_payload = (h == 0); in_last = (L == 1);
        in_data = wd[0]; in_bits = 8'(rawbits);
        fork
            begin
                for (int k = 1; k < L; k++) begin
                    @(negedge clk);
                    in_payload = (k >= h); in_last = (k == L-1); in_data = wd[k];
                end
                @(negedge clk);
                in_valid = 1'b0; in_payload = 1'b0; in_last = 1'b0;
            end
            begin
                for (int n = 1; n <= L + 15; n++) begin
                    @(negedge clk);
                    if (n >= h + 1 && n <= L + 1)
                        chk(ctr_valid && ctr_block == yv[n-h-1], "R4 counter block", ctr_block, yv[n-h-1]);
                    if (n == 12)
                        chk(gh_valid && gh_first && gh_data == ex[0], "R8 first hash word", gh_data, ex[0]);
                    if (n == 13)
                        chk(!out_valid, "R6 R10 quiet before first word", {127'd0, out_valid}, 128'd0);
                    if (n >= 14 && n < 14 + L) begin
                        int k = n - 14;
                        if (k < h)
                            chk(out_valid && out_type == 2'b01 && out_data == ex[k], "R2 R6 header passthrough", out_data, ex[k]);
                        else if (k == L-1)
                            chk(out_valid && out_type == 2'b10 && out_data == ex[k], "R3 R7 last ciphertext", out_data, ex[k]);
                        else
                            chk(out_valid && out_type == 2'b10 && out_data == ex[k], (L > 12) ? "R3 R10 ciphertext" : "R3 R5 ciphertext", out_data, ex[k]);
                    end
                    if (n == L + 12)
                        chk(gh_valid && !gh_first && gh_data == lens, "R8 lengths word", gh_data, lens);
                    if (n == L + 14)
                        chk(out_valid && out_type == 2'b11 && out_data == tag, "R9 R5 tag", out_data, tag);
                    if (n == L + 15)
                        chk(!out_valid, "R6 idle after tag", {127'd0, out_valid}, 128'd0);
                end
            end
        join
        repeat (16) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!out_valid && !ctr_valid && !gh_valid, "R1 reset state",
            {125'd0, out_valid, ctr_valid, gh_valid}, 128'd0);
        run_packet(1, 1, 128);
        run_packet(2, 20, 1);
        run_packet(1, 3, 0);
        run_packet(3, 12, 64);
        run_packet(1, 2, 200);
        for (int p = 0; p < 6; p++)
            run_packet(1 + int'($urandom % 4), 1 + int'($urandom % 16), 1 + int'($urandom % 128));
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule